// File: doc/BRIEF.md
# Complex and Real Multiply-Accumulate Unit

This block is the arithmetic engine that sits beside a scalar integer pipeline. Each accepted operation takes two operand words that the issuing logic has already read from the shared register file. A fixed number of cycles later it delivers a result into a dedicated result register and, for accumulating operations, updates one of two hardware accumulators. While an operation is in flight the unit raises `busy`. The integer side can keep issuing its own work during those cycles, and it holds any further arithmetic request until `issue_ready` returns.

Real operations work on 16-bit operands (bits 15:0 of each word) or on full 32-bit operands, as the `wide` input selects. Narrow real accumulation goes into a 32-bit accumulator. Wide real accumulation goes into a 64-bit accumulator. Complex operations view each operand word as a pair of signed 16-bit halves. They accumulate into the 64-bit accumulator, which they treat as two independent 32-bit halves.

Top module: `cmac_unit`

## Requirements
- R1: After reset `busy`, `res_valid`, `res_data`, `acc_w_o` and `acc_n_o` are all zero and `issue_ready` is one.
- R2: An operation accepted at a clock edge (`issue_valid` and `issue_ready` both high) writes its result at the edge LATENCY edges later (LATENCY >= 2, default 3). `res_valid` is high for exactly the one cycle that follows that edge.
- R3: `busy` is high from acceptance until the result is written. `issue_ready` is low while more than one cycle of latency remains and high in the final cycle, so a held request is accepted at the same edge that retires the previous one and no result is lost.
- R4: Opcode 0 (multiply) gives the signed product: 16x16 of bits 15:0 sign-extended to 64 bits when `wide`=0, full signed 32x32 when `wide`=1. Accumulators are unchanged.
- R5: Opcodes 1 (MAC) and 2 (MSU) with `wide`=0 add or subtract the signed 16x16 product to or from the 32-bit accumulator, modulo 2^32. The result is the new accumulator value sign-extended to 64 bits.
- R6: Opcodes 1 and 2 with `wide`=1 add or subtract the signed 32x32 product to or from the 64-bit accumulator, modulo 2^64. The result is the new value.
- R7: Opcode 3 (complex multiply) treats bits 31:16 as the signed real part and bits 15:0 as the signed imaginary part. It returns real = ar*br - ai*bi in result bits 63:32 and imag = ar*bi + ai*br in bits 31:0, each modulo 2^32.
- R8: Opcodes 4 (complex MAC) and 5 (complex MSU) add or subtract the real part into accumulator bits 63:32 and the imaginary part into bits 31:0. Each half wraps modulo 2^32 with no carry between halves. The result is the new 64-bit accumulator.
- R9: Opcodes 6 (complex add) and 7 (complex subtract) return the sign-extended 32-bit sum or difference of the real halves in bits 63:32 and of the imaginary halves in bits 31:0.
- R10: Opcode 8 clears both accumulators and returns zero. Opcodes 9 to 15 return zero and leave both accumulators unchanged.
- R11: The accumulators change only at the edge that writes a result.
- R12: `wide` has no effect on opcodes 3 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation request |
| issue_ready | output | 1 | Request is accepted at this edge when high |
| opcode | input | 4 | Operation code |
| wide | input | 1 | 1 = 32-bit real operands, 0 = 16-bit |
| opa | input | DATA_W | First operand word |
| opb | input | DATA_W | Second operand word |
| busy | output | 1 | Operation in flight |
| res_valid | output | 1 | Result register was written in the last edge |
| res_data | output | 2*DATA_W | Result register |
| acc_w_o | output | 2*DATA_W | 64-bit accumulator (complex: real high, imaginary low) |
| acc_n_o | output | DATA_W | 32-bit accumulator |

## Verification
A wrong accumulator value appears at `acc_w_o` or `acc_n_o` at once. It also shows up in `res_data` on the next accumulating operation, exactly LATENCY cycles after that operation is issued, so every retire compares both the result and the accumulators against a reference model. A wrong cycle count in the latency counter or the operand delay line shows as `res_valid` one cycle early or late, or as `issue_ready` opening too soon. In the stall case it shows as a retire carrying the operands of the wrong operation. The bench checks these things at fixed cycles from acceptance. Carry leaking between the complex halves only becomes visible when a half wraps, so the random stimulus is biased toward extreme half-word values.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_MUL  = 4'd0;
   localparam logic [OPC_W-1:0] OPC_MAC  = 4'd1;
   localparam logic [OPC_W-1:0] OPC_MSU  = 4'd2;
   localparam logic [OPC_W-1:0] OPC_CMUL = 4'd3;
   localparam logic [OPC_W-1:0] OPC_CMAC = 4'd4;
   localparam logic [OPC_W-1:0] OPC_CMSU = 4'd5;
   localparam logic [OPC_W-1:0] OPC_CADD = 4'd6;
   localparam logic [OPC_W-1:0] OPC_CSUB = 4'd7;
   localparam logic [OPC_W-1:0] OPC_CLR  = 4'd8;

   typedef enum logic [2:0] {
      K_NOP,
      K_MUL,
      K_MAC,
      K_CMUL,
      K_CMAC,
      K_CADD,
      K_CLR
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  sub;
      logic  wide;
   } ctrl_t;
endpackage

// File: rtl/cmac_decode.sv
module cmac_decode
   import cmac_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic             wide,
   output ctrl_t            ctrl
);
   always_comb begin
      ctrl.kind = K_NOP;
      ctrl.sub  = 1'b0;
      ctrl.wide = 1'b0;
      unique case (opcode)
         OPC_MUL:  begin ctrl.kind = K_MUL;  ctrl.wide = wide; end
         OPC_MAC:  begin ctrl.kind = K_MAC;  ctrl.wide = wide; end
         OPC_MSU:  begin ctrl.kind = K_MAC;  ctrl.wide = wide; ctrl.sub = 1'b1; end
         OPC_CMUL: ctrl.kind = K_CMUL;
         OPC_CMAC: ctrl.kind = K_CMAC;
         OPC_CMSU: begin ctrl.kind = K_CMAC; ctrl.sub = 1'b1; end
         OPC_CADD: ctrl.kind = K_CADD;
         OPC_CSUB: begin ctrl.kind = K_CADD; ctrl.sub = 1'b1; end
         OPC_CLR:  ctrl.kind = K_CLR;
         default:  ctrl.kind = K_NOP;
      endcase
   end
endmodule

// File: rtl/cmac_mult.sv
module cmac_mult
   import cmac_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  ctrl_t                   ctrl,
   input  logic [DATA_W-1:0]       a,
   input  logic [DATA_W-1:0]       b,
   output logic [2*DATA_W-1:0]     p_real,
   output logic [DATA_W-1:0]       c_re,
   output logic [DATA_W-1:0]       c_im,
   output logic [DATA_W-1:0]       s_re,
   output logic [DATA_W-1:0]       s_im
);
   localparam int HALF_W = DATA_W / 2;
   localparam int PROD_W = 2 * DATA_W;

   // Sign-extended half-words: high half is the real part, low half the imaginary part.
   logic signed [DATA_W-1:0] ar, ai, br, bi;
   assign ar = DATA_W'($signed(a[DATA_W-1:HALF_W]));
   assign ai = DATA_W'($signed(a[HALF_W-1:0]));
   assign br = DATA_W'($signed(b[DATA_W-1:HALF_W]));
   assign bi = DATA_W'($signed(b[HALF_W-1:0]));

   // Full-width signed operands for the wide real product.
   logic signed [PROD_W-1:0] aw, bw, pw;
   assign aw = PROD_W'($signed(a));
   assign bw = PROD_W'($signed(b));
   assign pw = aw * bw;

   // Four half-word partial products; the narrow real product reuses the low pair.
   logic signed [DATA_W-1:0] rr, ii, ri, ir;
   assign rr = ar * br;
   assign ii = ai * bi;
   assign ri = ar * bi;
   assign ir = ai * br;

   assign p_real = ctrl.wide ? pw : {{DATA_W{ii[DATA_W-1]}}, ii};
   assign c_re   = rr - ii;
   assign c_im   = ri + ir;
   assign s_re   = ctrl.sub ? (ar - br) : (ar + br);
   assign s_im   = ctrl.sub ? (ai - bi) : (ai + bi);
endmodule

// File: rtl/cmac_pipe.sv
module cmac_pipe #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign dout = stg[DEPTH-1];
endmodule

// File: rtl/cmac_accum.sv
module cmac_accum
   import cmac_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ret,
   input  ctrl_t               ctrl,
   input  logic [2*DATA_W-1:0] p_real,
   input  logic [DATA_W-1:0]   c_re,
   input  logic [DATA_W-1:0]   c_im,
   input  logic [DATA_W-1:0]   s_re,
   input  logic [DATA_W-1:0]   s_im,
   output logic [2*DATA_W-1:0] acc_w,
   output logic [DATA_W-1:0]   acc_n,
   output logic [2*DATA_W-1:0] res,
   output logic                res_valid
);
   localparam int PROD_W = 2 * DATA_W;

   logic [PROD_W-1:0] nxt_w, nxt_r;
   logic [DATA_W-1:0] nxt_n, hi, lo;

   always_comb begin
      nxt_w = acc_w;
      nxt_n = acc_n;
      nxt_r = '0;
      hi    = '0;
      lo    = '0;
      unique case (ctrl.kind)
         K_MUL:  nxt_r = p_real;
         K_MAC: begin
            if (ctrl.wide) begin
               nxt_w = ctrl.sub ? (acc_w - p_real) : (acc_w + p_real);
               nxt_r = nxt_w;
            end else begin
               nxt_n = ctrl.sub ? (acc_n - p_real[DATA_W-1:0])
                                : (acc_n + p_real[DATA_W-1:0]);
               nxt_r = {{DATA_W{nxt_n[DATA_W-1]}}, nxt_n};
            end
         end
         K_CMUL: nxt_r = {c_re, c_im};
         K_CMAC: begin
            hi    = ctrl.sub ? (acc_w[PROD_W-1:DATA_W] - c_re) : (acc_w[PROD_W-1:DATA_W] + c_re);
            lo    = ctrl.sub ? (acc_w[DATA_W-1:0] - c_im)      : (acc_w[DATA_W-1:0] + c_im);
            nxt_w = {hi, lo};
            nxt_r = nxt_w;
         end
         K_CADD: nxt_r = {s_re, s_im};
         K_CLR: begin
            nxt_w = '0;
            nxt_n = '0;
         end
         default: nxt_r = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_w     <= '0;
         acc_n     <= '0;
         res       <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= ret;
         if (ret) begin
            acc_w <= nxt_w;
            acc_n <= nxt_n;
            res   <= nxt_r;
         end
      end
   end
endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
   import cmac_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LATENCY = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue_valid,
   output logic                issue_ready,
   input  logic [3:0]          opcode,
   input  logic                wide,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   output logic                busy,
   output logic                res_valid,
   output logic [2*DATA_W-1:0] res_data,
   output logic [2*DATA_W-1:0] acc_w_o,
   output logic [DATA_W-1:0]   acc_n_o
);
   localparam int CNT_W  = $clog2(LATENCY + 1);
   localparam int CTRL_W = $bits(ctrl_t);
   localparam int BUN_W  = CTRL_W + 6 * DATA_W;
   localparam int PIPE_D = LATENCY - 1;

   if (LATENCY < 2) begin : g_bad_latency
      $error("cmac_unit: LATENCY must be at least 2");
   end
   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
      $error("cmac_unit: DATA_W must be even and at least 4");
   end

   // Issue control: one counter spans the latency of the operation in flight.
   logic [CNT_W-1:0] cnt;
   logic             fire, ret;

   assign issue_ready = (cnt <= CNT_W'(1));
   assign fire        = issue_valid && issue_ready;
   assign ret         = (cnt == CNT_W'(1));
   assign busy        = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (fire) cnt <= CNT_W'(LATENCY);
      else if (busy) cnt <= cnt - CNT_W'(1);
   end

   // Operand capture
   ctrl_t             ctrl_d, ctrl_q;
   logic [DATA_W-1:0] a_q, b_q;

   cmac_decode u_decode (
      .opcode (opcode),
      .wide   (wide),
      .ctrl   (ctrl_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         a_q    <= '0;
         b_q    <= '0;
      end else if (fire) begin
         ctrl_q <= ctrl_d;
         a_q    <= opa;
         b_q    <= opb;
      end
   end

   // Product generation
   logic [2*DATA_W-1:0] p_real;
   logic [DATA_W-1:0]   c_re, c_im, s_re, s_im;

   cmac_mult #(.DATA_W(DATA_W)) u_mult (
      .ctrl   (ctrl_q),
      .a      (a_q),
      .b      (b_q),
      .p_real (p_real),
      .c_re   (c_re),
      .c_im   (c_im),
      .s_re   (s_re),
      .s_im   (s_im)
   );

   // Latency pipeline carrying control and products to the retire edge
   logic [BUN_W-1:0] bun_in, bun_out;
   assign bun_in = {ctrl_q, p_real, c_re, c_im, s_re, s_im};

   cmac_pipe #(.WIDTH(BUN_W), .DEPTH(PIPE_D)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (bun_in),
      .dout  (bun_out)
   );

   ctrl_t               ctrl_r;
   logic [2*DATA_W-1:0] p_real_r;
   logic [DATA_W-1:0]   c_re_r, c_im_r, s_re_r, s_im_r;
   assign {ctrl_r, p_real_r, c_re_r, c_im_r, s_re_r, s_im_r} = bun_out;

   cmac_accum #(.DATA_W(DATA_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .ret       (ret),
      .ctrl      (ctrl_r),
      .p_real    (p_real_r),
      .c_re      (c_re_r),
      .c_im      (c_im_r),
      .s_re      (s_re_r),
      .s_im      (s_im_r),
      .acc_w     (acc_w_o),
      .acc_n     (acc_n_o),
      .res       (res_data),
      .res_valid (res_valid)
   );
endmodule

// File: rtl/cmac_unit_chk.sv
module cmac_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int LATENCY = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                issue_valid,
   input logic                issue_ready,
   input logic                busy,
   input logic                res_valid,
   input logic [2*DATA_W-1:0] acc_w_o,
   input logic [DATA_W-1:0]   acc_n_o
);
   localparam int TW = $clog2(LATENCY + 1);

   // Independent count of cycles left for the operation in flight.
   logic [TW-1:0] trk;
   always_ff @(posedge clk) begin
      if (!rst_n)                          trk <= '0;
      else if (issue_valid && issue_ready) trk <= TW'(LATENCY);
      else if (trk != '0)                  trk <= trk - TW'(1);
   end

   // R2: result follows the last latency cycle
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trk == TW'(1)) |=> res_valid);

   // R2: no result without an operation finishing
   assert_no_stray_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(trk) == TW'(1)));

   // R2: result strobe lasts one cycle
   assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R3: stall while more than one latency cycle remains
   assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trk > TW'(1)) |-> (!issue_ready && busy));

   // R3: idle unit is ready and not busy
   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trk == '0) |-> (issue_ready && !busy));

   // R11: accumulators move only together with a result
   assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(acc_w_o) || !$stable(acc_n_o)) |-> res_valid);
endmodule

bind cmac_unit cmac_unit_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .busy        (busy),
   .res_valid   (res_valid),
   .acc_w_o     (acc_w_o),
   .acc_n_o     (acc_n_o)
);

// File: tb/cmac_unit_bench.sv
module cmac_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 32;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          issue_valid;
   logic          issue_ready;
   logic [3:0]    opcode;
   logic          wide;
   logic [DW-1:0] opa, opb;
   logic          busy, res_valid;
   logic [63:0]   res_data, acc_w_o;
   logic [31:0]   acc_n_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [63:0] mdl_w;
   logic [31:0] mdl_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmac_unit #(.DATA_W(DW), .LATENCY(LAT)) u_cmac_unit (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .opcode(opcode), .wide(wide), .opa(opa), .opb(opb), .busy(busy),
      .res_valid(res_valid), .res_data(res_data), .acc_w_o(acc_w_o), .acc_n_o(acc_n_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input logic [3:0] opc, input logic w);
      case (opc)
         4'd0:        return "R4";
         4'd1, 4'd2:  return w ? "R6" : "R5";
         4'd3:        return "R7";
         4'd4, 4'd5:  return "R8";
         4'd6, 4'd7:  return "R9";
         default:     return "R10";
      endcase
   endfunction

   // Reference model: updates mdl_w / mdl_n and returns the expected result.
   task automatic model(input logic [3:0] opc, input logic w, input logic [31:0] a,
                        input logic [31:0] b, output logic [63:0] r);
      longint ar, ai, br, bi, pn, pw, re, im;
      logic [31:0] hi, lo;
      ar = longint'(shortint'(a[31:16]));
      ai = longint'(shortint'(a[15:0]));
      br = longint'(shortint'(b[31:16]));
      bi = longint'(shortint'(b[15:0]));
      pn = ai * bi;
      pw = longint'(int'(a)) * longint'(int'(b));
      re = ar * br - ai * bi;
      im = ar * bi + ai * br;
      r = 64'd0;
      case (opc)
         4'd0: r = w ? 64'(pw) : 64'(pn);
         4'd1, 4'd2: begin
            if (w) begin
               mdl_w = (opc == 4'd1) ? mdl_w + 64'(pw) : mdl_w - 64'(pw);
               r = mdl_w;
            end else begin
               mdl_n = (opc == 4'd1) ? mdl_n + 32'(pn) : mdl_n - 32'(pn);
               r = 64'(longint'(int'(mdl_n)));
            end
         end
         4'd3: r = {32'(re), 32'(im)};
         4'd4, 4'd5: begin
            hi = (opc == 4'd4) ? mdl_w[63:32] + 32'(re) : mdl_w[63:32] - 32'(re);
            lo = (opc == 4'd4) ? mdl_w[31:0]  + 32'(im) : mdl_w[31:0]  - 32'(im);
            mdl_w = {hi, lo};
            r = mdl_w;
         end
         4'd6: r = {32'(ar + br), 32'(ai + bi)};
         4'd7: r = {32'(ar - br), 32'(ai - bi)};
         4'd8: begin mdl_w = '0; mdl_n = '0; end
         default: r = 64'd0;
      endcase
   endtask

   // One isolated operation with timing checks.
   task automatic do_op(input logic [3:0] opc, input logic w, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
      logic [63:0] exp;
      logic [63:0] old_w;
      logic [31:0] old_n;
      old_w = mdl_w;
      old_n = mdl_n;
      model(opc, w, a, b, exp);
      chk("R3 ready before issue", 64'(issue_ready), 64'd1);
      issue_valid = 1'b1; opcode = opc; wide = w; opa = a; opb = b;
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      chk("R3 busy after issue", 64'({busy, issue_ready}), 64'b10);
      for (int i = 0; i < LAT - 2; i++) @(negedge clk);
      @(negedge clk);
      chk("R2 no result early", 64'({res_valid, issue_ready}), 64'b01);
      chk("R11 acc64 held", acc_w_o, old_w);
      chk("R11 acc32 held", 64'(acc_n_o), 64'(old_n));
      @(negedge clk);
      chk("R2 result strobe", 64'({res_valid, busy}), 64'b10);
      chk({tag, " result"}, res_data, exp);
      chk({tag, " acc64"}, acc_w_o, mdl_w);
      chk({tag, " acc32"}, 64'(acc_n_o), 64'(mdl_n));
   endtask

   function automatic logic [31:0] pick_word();
      case ($urandom_range(0, 7))
         0: return 32'h8000_8000;
         1: return 32'h7FFF_7FFF;
         2: return 32'h8000_7FFF;
         3: return 32'hFFFF_FFFF;
         4: return 32'h8000_0000;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [63:0] ea, eb;
      logic [63:0] r0, r1;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; issue_valid = 1'b0; opcode = '0; wide = 1'b0; opa = '0; opb = '0;
      mdl_w = '0; mdl_n = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 reset res/acc", res_data | acc_w_o | 64'(acc_n_o), 64'd0);
      chk("R1 reset flags", 64'({busy, res_valid, issue_ready}), 64'b001);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after release", 64'({busy, res_valid, issue_ready}), 64'b001);

      // Directed corners
      do_op(4'd0, 1'b0, 32'h1234_FFFD, 32'h0000_0005, "R4 narrow mul");
      do_op(4'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R4 wide mul");
      do_op(4'd1, 1'b0, 32'h0000_8000, 32'h0000_8000, "R5 mac");
      do_op(4'd1, 1'b0, 32'h0000_8000, 32'h0000_8000, "R5 mac wrap");
      do_op(4'd2, 1'b0, 32'h0000_7FFF, 32'h0000_0003, "R5 msu");
      do_op(4'd2, 1'b1, 32'h7FFF_FFFF, 32'h8000_0000, "R6 wide msu");
      do_op(4'd3, 1'b0, 32'h8000_8000, 32'h8000_7FFF, "R7 cmul");
      do_op(4'd3, 1'b1, 32'h8000_8000, 32'h8000_7FFF, "R12 cmul wide");
      do_op(4'd4, 1'b1, 32'h8000_8000, 32'h8000_8000, "R12 cmac wide");
      do_op(4'd4, 1'b0, 32'h8000_8000, 32'h8000_8000, "R8 cmac wrap halves");
      do_op(4'd5, 1'b0, 32'h7FFF_8000, 32'h7FFF_7FFF, "R8 cmsu");
      do_op(4'd6, 1'b0, 32'h7FFF_8000, 32'h7FFF_8000, "R9 cadd");
      do_op(4'd7, 1'b1, 32'h8000_7FFF, 32'h7FFF_8000, "R9 csub");
      do_op(4'd12, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 unused code");
      do_op(4'd8, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 clear");

      // Stalled request held while busy: accepted at the retiring edge
      mdl_w = 64'h0; mdl_n = 32'h0;
      model(4'd1, 1'b0, 32'h0000_0007, 32'h0000_0009, ea);
      model(4'd4, 1'b0, 32'h0003_0002, 32'h0005_FFFF, eb);
      issue_valid = 1'b1; opcode = 4'd1; wide = 1'b0; opa = 32'h0000_0007; opb = 32'h0000_0009;
      @(posedge clk);
      @(negedge clk);
      opcode = 4'd4; opa = 32'h0003_0002; opb = 32'h0005_FFFF;
      chk("R3 held request stalled", 64'(issue_ready), 64'd0);
      for (int i = 0; i < LAT - 1; i++) @(negedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      r0 = res_data;
      chk("R3 first result kept", {63'd0, res_valid}, 64'd1);
      chk("R3 first result value", r0, ea);
      chk("R3 second in flight", 64'({busy, issue_ready}), 64'b10);
      for (int i = 0; i < LAT - 1; i++) @(negedge clk);
      @(negedge clk);
      r1 = res_data;
      chk("R3 second result strobe", {63'd0, res_valid}, 64'd1);
      chk("R8 second result value", r1, eb);
      chk("R8 acc after stall", acc_w_o, mdl_w);

      // Constrained random
      for (int n = 0; n < 600; n++) begin
         logic [3:0] opc;
         logic w;
         int sel;
         sel = $urandom_range(0, 10);
         opc = (sel >= 9) ? 4'($urandom_range(9, 15)) : 4'(sel);
         if (sel == 8 && $urandom_range(0, 3) != 0) opc = 4'd1;
         w = 1'($urandom_range(0, 1));
         do_op(opc, w, pick_word(), pick_word(), tag_of(opc, w));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule